// File: doc/BRIEF.md
# Priority-Selected Variable Delay Pulser

The block waits for one of four active-low request lines to go low, picks one delay from them with a fixed priority rule, counts that many clock cycles and then drops its active-low output for a single cycle. The four lines ask for delays of 1, 3, 9 and 14 cycles. Once counting starts, the request lines have no effect until the output pulse has been produced. If a request is still low during the pulse cycle, the next delay starts straight away. Otherwise the block goes back to idle.

The whole sequence is held in one 4-bit state register. Code 0 means idle. The all-ones code is the pulse state. The codes in between are count states, and the block steps upward through them one per clock. A delay of N loads the code that lies N steps below the pulse code. The output is decoded from the state register alone.

An active-low asynchronous reset abandons any delay in progress and does so without a pulse.

Top module: `vdly_pulser`

## Requirements
- R1: While rst_ni is low the output is high and the block is idle. A delay that was running when reset arrived never produces a pulse, and after reset is released the output stays high until a new request is sampled.
- R2: While idle with all four request lines high, the block stays idle and pulse_no stays high.
- R3: A request is sampled at a rising clock edge E. With bit 0 = 1 cycle, bit 1 = 3 cycles, bit 2 = 9 cycles and bit 3 = 14 cycles, pulse_no is low in the cycle that follows the Nth rising edge after E, and high in the cycles before it.
- R4: pulse_no is low for exactly one clock cycle per completed delay.
- R5: When several request bits are low at the sampling edge, the delay is chosen in this order: bit 0 (1 cycle), then bit 2 (9 cycles), then bit 1 (3 cycles), then bit 3 (14 cycles).
- R6: While a delay is counting, any value on req_ni changes neither the timing of the pending pulse nor the delay that was chosen.
- R7: If a request is low at the edge that ends the pulse cycle, a new delay starts from that edge, so a request held low for N cycles gives a pulse every N+1 cycles.
- R8: pulse_no depends only on registered state. A change on req_ni between clock edges does not change it within that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; aborts any delay |
| req_ni | input | 4 | Active-low delay requests: bit 0 = 1, bit 1 = 3, bit 2 = 9, bit 3 = 14 cycles |
| pulse_no | output | 1 | Active-low one-cycle pulse when the delay completes |

## Verification
Every result is counted in rising edges from the edge that samples the request. The pulse is due in the cycle after edge N, and it must be gone again after edge N+1. The bench drives each stimulus just after a falling edge and samples pulse_no at the following falling edges. Counting the edges one at a time, it checks every cycle from edge 0 up to edge N+2.

It sweeps all sixteen request patterns and works out each expected delay from the priority rule. During counting it drives changing junk patterns onto the request lines. Separate runs cover a request held low without a break (pulses N+1 cycles apart), a reset in the middle of a delay, and a request changed between edges, which is sampled 1 ns later.

// File: rtl/vdly_pkg.sv
package vdly_pkg;
  localparam int unsigned NUM_REQ    = 4;
  localparam int unsigned ST_W       = 4;
  localparam int unsigned PULSE_CODE = (1 << ST_W) - 1;
  typedef logic [ST_W-1:0]    st_t;
  typedef logic [NUM_REQ-1:0] req_t;
endpackage

// File: rtl/vdly_prio_sel.sv
module vdly_prio_sel
  import vdly_pkg::*;
#(
  parameter int unsigned PRIO [NUM_REQ] = '{0, 2, 1, 3}
) (
  input  req_t req_ni,
  output req_t grant_o,
  output logic any_o
);
  logic [NUM_REQ:0] taken;

  // walk ranks from highest to lowest; first low request wins
  always_comb begin
    grant_o  = '0;
    taken[0] = 1'b0;
    for (int r = 0; r < NUM_REQ; r++) begin
      grant_o[PRIO[r]] = ~req_ni[PRIO[r]] & ~taken[r];
      taken[r+1]       = taken[r] | ~req_ni[PRIO[r]];
    end
  end

  assign any_o = taken[NUM_REQ];
endmodule

// File: rtl/vdly_load_mux.sv
module vdly_load_mux
  import vdly_pkg::*;
#(
  parameter int unsigned DELAYS [NUM_REQ] = '{1, 3, 9, 14}
) (
  input  req_t grant_i,
  output st_t  load_o
);
  st_t term [NUM_REQ];

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_term
    localparam st_t LOAD_C = st_t'(PULSE_CODE - DELAYS[i]);
    assign term[i] = grant_i[i] ? LOAD_C : '0;
  end

  always_comb begin
    load_o = '0;
    for (int i = 0; i < NUM_REQ; i++) load_o |= term[i];
  end
endmodule

// File: rtl/vdly_seq.sv
module vdly_seq
  import vdly_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  st_t  load_i,
  output st_t  st_o,
  output logic pulse_no
);
  localparam st_t PULSE_C = st_t'(PULSE_CODE);

  st_t  st_q, st_d;
  logic open_w;

  // idle and pulse states both accept a new request
  assign open_w = (st_q == '0) || (st_q == PULSE_C);

  always_comb begin
    if (open_w) st_d = start_i ? load_i : '0;
    else        st_d = st_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o     = st_q;
  assign pulse_no = ~(st_q == PULSE_C);
endmodule

// File: rtl/vdly_pulser.sv
module vdly_pulser
  import vdly_pkg::*;
#(
  parameter int unsigned DELAYS [NUM_REQ] = '{1, 3, 9, 14},
  parameter int unsigned PRIO   [NUM_REQ] = '{0, 2, 1, 3}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_REQ-1:0]   req_ni,
  output logic                 pulse_no
);
  req_t grant_w;
  logic any_w;
  st_t  load_w;
  st_t  st_w;

  vdly_prio_sel #(.PRIO(PRIO)) u_prio (
    .req_ni (req_ni),
    .grant_o(grant_w),
    .any_o  (any_w)
  );

  vdly_load_mux #(.DELAYS(DELAYS)) u_load (
    .grant_i(grant_w),
    .load_o (load_w)
  );

  vdly_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (any_w),
    .load_i  (load_w),
    .st_o    (st_w),
    .pulse_no(pulse_no)
  );
endmodule

// File: rtl/vdly_pulser_chk.sv
module vdly_pulser_chk
  import vdly_pkg::*;
#(
  parameter int unsigned TOP_DELAY = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input req_t req_ni,
  input st_t  st_i,
  input logic pulse_no
);
  localparam st_t PULSE_C = st_t'(PULSE_CODE);
  localparam st_t TOP_LD  = st_t'(PULSE_CODE - TOP_DELAY);

  // R4: never two low cycles in a row
  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_no |=> pulse_no);

  // R2: idle with no request stays idle and quiet
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == '0 && &req_ni) |=> (st_i == '0 && pulse_no));

  // R5: top-ranked request wins whenever the block is open
  a_r5_top_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == '0 || st_i == PULSE_C) && !req_ni[0]) |=> (st_i == TOP_LD));

  // R6: counting ignores requests
  a_r6_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != '0 && st_i != PULSE_C) |=> (st_i == st_t'($past(st_i) + 1'b1)));

  // R3: last count step yields the pulse
  a_r3_last_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == PULSE_C - 1'b1) |=> !pulse_no);
endmodule

bind vdly_pulser vdly_pulser_chk #(.TOP_DELAY(DELAYS[PRIO[0]])) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_ni  (req_ni),
  .st_i    (st_w),
  .pulse_no(pulse_no)
);

// File: tb/sim_vdly_pulser.sv
`timescale 1ns/1ps
module sim_vdly_pulser;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_ni = 4'hF;
  logic       pulse_no;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  vdly_pulser u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_ni  (req_ni),
    .pulse_no(pulse_no)
  );

  function automatic int exp_delay(input logic [3:0] p);
    if (!p[0]) return 1;
    if (!p[2]) return 9;
    if (!p[1]) return 3;
    if (!p[3]) return 14;
    return 0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pulse_no=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // pattern sampled at next edge (E0); checks edges 0..N+2
  task automatic run_pattern(input logic [3:0] pat);
    int n;
    n = exp_delay(pat);
    req_ni = pat;
    #1 chk("R8", pulse_no, 1'b1);
    step();
    if (n == 0) begin
      for (int k = 0; k < 20; k++) begin
        chk("R2", pulse_no, 1'b1);
        step();
      end
      return;
    end
    chk("R3", pulse_no, (n == 0) ? 1'b0 : 1'b1);
    for (int k = 1; k <= n + 2; k++) begin
      req_ni = (k >= n - 1) ? 4'hF : 4'((k * 7) ^ pat); // R6 junk while counting
      step();
      if (k == n) chk("R3/R5/R6", pulse_no, 1'b0);
      else if (k == n + 1) chk("R4", pulse_no, 1'b1);
      else chk("R3/R6", pulse_no, 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", pulse_no, 1'b1);
    rst_ni = 1'b1;
    step();
    chk("R1", pulse_no, 1'b1);

    for (int p = 0; p < 16; p++) run_pattern(4'(p));

    // R7: 3-cycle request held low -> pulse every 4 cycles
    req_ni = 4'b1101;
    step();
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R7", pulse_no, (k % 4 == 3) ? 1'b0 : 1'b1);
    end
    req_ni = 4'hF;
    repeat (6) step();

    // R1: reset in the middle of a 14-cycle delay
    req_ni = 4'b0111;
    step();
    req_ni = 4'hF;
    repeat (5) step();
    rst_ni = 1'b0;
    #1 chk("R1", pulse_no, 1'b1);
    step();
    chk("R1", pulse_no, 1'b1);
    rst_ni = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      chk("R1", pulse_no, 1'b1);
    end

    // R5: all requests low picks 1 cycle
    run_pattern(4'b0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: timeout reached, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule